// File: doc/BRIEF.md
# Numerically Controlled Oscillator Phase Core

This block is the phase datapath of a direct digital synthesizer. On every master clock edge it adds a 32-bit tuning word to a 32-bit phase accumulator. The tuning word is picked from two programmed words by a 1-bit select. The upper 12 bits of the updated accumulator are then added to a 12-bit phase offset, picked from four programmed offsets by a 2-bit select. The registered sum is the phase word handed to a downstream sine lookup. The output frequency is the tuning word times the clock frequency divided by 2^32. One offset LSB is 2π/4096 radians.

Three control flags shape the run. A reset flag zeroes the accumulator and holds it there. A sleep flag freezes the accumulated phase and marks the output invalid. A clear flag restarts the accumulation from zero without dropping the valid flag. Enabling the output means driving all three flags low. Disabling it means raising only the reset flag. Select inputs may change on any cycle and act at the next accumulator update.

Top module: `nco_phase_core`

## Requirements
- R1: While `rst_n` is low, and until the first edge after its synchronous release, `phase_word` is 0 and `phase_vld` is 0. The accumulator is 0.
- R2: With all flags low, each clock edge adds the selected tuning word to the accumulator. `ftw_sel`=0 picks bits [31:0] of `ftw_words` and 1 picks bits [63:32]. In that same edge, `phase_word` becomes accumulator bits [31:20] plus the selected offset, and `phase_vld` goes to 1.
- R3: `poff_sel` value k picks offset bits [12k+11:12k] of `poff_words`. The addition to the accumulator's top bits wraps modulo 4096.
- R4: A change of either select acts at the next edge. It does not alter the phase already accumulated.
- R5: While `rst_req` is high, the accumulator is 0, `phase_word` is 0 and `phase_vld` is 0. The first running edge after release gives an accumulator equal to one tuning word.
- R6: While `sleep_req` is high and the other flags are low, the accumulator and `phase_word` hold their values and `phase_vld` is 0. A run that resumes continues from the held phase.
- R7: An edge with `clr_req` high (reset and sleep flags low) zeroes the accumulator. `phase_word` becomes the selected offset and `phase_vld` stays 1.
- R8: Priority is reset flag, then clear, then sleep. Clear together with sleep zeroes the accumulator, holds `phase_word` and drives `phase_vld` to 0. With the reset flag high, the other flags have no effect.
- R9: A selected tuning word above 2^31 (beyond half the clock rate) must not be used while running. A word of exactly 2^31 makes `phase_word` alternate between 0x800 and 0x000 when the offset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ftw_words | input | 64 | Two tuning words; word 0 in bits [31:0] |
| poff_words | input | 48 | Four 12-bit phase offsets; offset k in bits [12k+11:12k] |
| ftw_sel | input | 1 | Tuning word select |
| poff_sel | input | 2 | Phase offset select |
| sleep_req | input | 1 | Freeze phase, mark output invalid |
| rst_req | input | 1 | Hold accumulator and output at zero |
| clr_req | input | 1 | Restart accumulation from zero |
| phase_word | output | 12 | Registered phase word for the sine lookup |
| phase_vld | output | 1 | Phase word valid |

## Verification
On every cycle, the assertions check the accumulator step for each mode: add, hold, or force to zero. They also check that the phase word is the updated top bits plus the offset, that sleep freezes the word and drops valid, and that no tuning word above half the clock rate is used while running. The bench's scenarios alone show the things that need a known history. These include the exact phase values across select changes, the modulo-4096 wrap of the offset sum, and resumption after sleep from the held phase. They also cover the priority when several flags are high together and the alternating pattern at the Nyquist tuning word.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // accumulator update mode chosen from the control flags
  typedef enum logic [1:0] {
    ACC_RUN  = 2'd0,
    ACC_HOLD = 2'd1,
    ACC_ZERO = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/nco_rst_sync.sv
module nco_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/nco_word_sel.sv
module nco_word_sel #(
  parameter int W = 32,
  parameter int N = 2,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*W-1:0] words,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   word
);
  logic [W-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign slot[g] = words[g*W +: W];
  end

  if (N == 1) begin : g_single
    assign word = slot[0];
  end else begin : g_multi
    always_comb begin
      word = slot[0];
      for (int i = 0; i < N; i++) begin
        if (sel == SW'(i)) word = slot[i];
      end
    end
  end
endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_mode_e        mode,
  input  logic [ACC_W-1:0] ftw,
  output logic [ACC_W-1:0] acc_d,
  output logic [ACC_W-1:0] acc_q
);
  logic acc_en;

  always_comb begin
    acc_en = 1'b1;
    unique case (mode)
      ACC_RUN:  acc_d = acc_q + ftw;
      ACC_ZERO: acc_d = '0;
      ACC_HOLD: begin
        acc_d  = acc_q;
        acc_en = 1'b0;
      end
      default: begin
        acc_d  = acc_q;
        acc_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACC_RUN) |=> (acc_q == $past(acc_q) + $past(ftw)));

  assert_acc_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACC_ZERO) |=> (acc_q == '0));

  assert_acc_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == ACC_HOLD) |=> $stable(acc_q));
endmodule

// File: rtl/nco_phase_stage.sv
module nco_phase_stage #(
  parameter int PH_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] acc_top,
  input  logic [PH_W-1:0] poff,
  input  logic            hold,
  input  logic            zero,
  output logic [PH_W-1:0] phase_q,
  output logic            vld_q
);
  logic [PH_W-1:0] phase_d;
  logic            vld_d;

  always_comb begin
    if (zero) begin
      phase_d = '0;
      vld_d   = 1'b0;
    end else if (hold) begin
      phase_d = phase_q;
      vld_d   = 1'b0;
    end else begin
      phase_d = acc_top + poff;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      vld_q   <= vld_d;
    end
  end

  assert_phase_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !hold) |=> (vld_q && phase_q == PH_W'($past(acc_top) + $past(poff))));

  assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !zero) |=> (!vld_q && $stable(phase_q)));

  assert_zero_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (!vld_q && phase_q == '0));
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int PH_W   = 12,
  parameter int N_FTW  = 2,
  parameter int N_POFF = 4,
  localparam int FS_W  = (N_FTW > 1) ? $clog2(N_FTW) : 1,
  localparam int PS_W  = (N_POFF > 1) ? $clog2(N_POFF) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_FTW*ACC_W-1:0]  ftw_words,
  input  logic [N_POFF*PH_W-1:0]  poff_words,
  input  logic [FS_W-1:0]         ftw_sel,
  input  logic [PS_W-1:0]         poff_sel,
  input  logic                    sleep_req,
  input  logic                    rst_req,
  input  logic                    clr_req,
  output logic [PH_W-1:0]         phase_word,
  output logic                    phase_vld
);
  localparam logic [ACC_W-1:0] FTW_MAX = ACC_W'(1) << (ACC_W - 1);

  logic             rst_n_s;
  logic [ACC_W-1:0] ftw_cur;
  logic [PH_W-1:0]  poff_cur;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] acc_q;
  acc_mode_e        mode;

  nco_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  nco_word_sel #(.W(ACC_W), .N(N_FTW)) u_ftw_sel (
    .words (ftw_words),
    .sel   (ftw_sel),
    .word  (ftw_cur)
  );

  nco_word_sel #(.W(PH_W), .N(N_POFF)) u_poff_sel (
    .words (poff_words),
    .sel   (poff_sel),
    .word  (poff_cur)
  );

  // flag priority: reset flag, then clear, then sleep
  always_comb begin
    if (rst_req || clr_req) mode = ACC_ZERO;
    else if (sleep_req)     mode = ACC_HOLD;
    else                    mode = ACC_RUN;
  end

  nco_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .mode  (mode),
    .ftw   (ftw_cur),
    .acc_d (acc_d),
    .acc_q (acc_q)
  );

  nco_phase_stage #(.PH_W(PH_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .acc_top (acc_d[ACC_W-1 -: PH_W]),
    .poff    (poff_cur),
    .hold    (sleep_req),
    .zero    (rst_req),
    .phase_q (phase_word),
    .vld_q   (phase_vld)
  );

  assert_nyquist_limit_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode == ACC_RUN) |-> (ftw_cur <= FTW_MAX));

  assert_clear_restart_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clr_req && !rst_req && !sleep_req) |=> (acc_q == '0 && phase_vld && phase_word == $past(poff_cur)));

  assert_flag_priority_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    rst_req |=> (acc_q == '0 && !phase_vld && phase_word == '0));
endmodule

// File: tb/tb_nco_phase_core.sv
`timescale 1ns/1ps
module tb_nco_phase_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ftw0, ftw1;
  logic [63:0] ftw_words;
  logic [47:0] poff_words;
  logic        ftw_sel;
  logic [1:0]  poff_sel;
  logic        sleep_req, rst_req, clr_req;
  logic [11:0] phase_word;
  logic        phase_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  assign ftw_words  = {ftw1, ftw0};
  assign poff_words = {12'hFFF, 12'h800, 12'h100, 12'h000};

  nco_phase_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ftw_words  (ftw_words),
    .poff_words (poff_words),
    .ftw_sel    (ftw_sel),
    .poff_sel   (poff_sel),
    .sleep_req  (sleep_req),
    .rst_req    (rst_req),
    .clr_req    (clr_req),
    .phase_word (phase_word),
    .phase_vld  (phase_vld)
  );

  // fields: [18] fsel, [17:16] psel, [15] sleep, [14] rst flag, [13] clr, [12:1] phase, [0] vld
  // ftw0 = 0x0100_0000 (+16 on top bits), ftw1 = 0x0040_0000 (+4); offsets 0,0x100,0x800,0xFFF
  localparam int NV = 18;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 3'b000, 12'h010, 1'b1},  // R2 first step
    {1'b0, 2'd0, 3'b000, 12'h020, 1'b1},  // R2
    {1'b1, 2'd0, 3'b000, 12'h024, 1'b1},  // R4 switch to word 1
    {1'b1, 2'd1, 3'b000, 12'h128, 1'b1},  // R3 offset 1
    {1'b0, 2'd2, 3'b000, 12'h838, 1'b1},  // R4 both selects change
    {1'b0, 2'd3, 3'b000, 12'h047, 1'b1},  // R3 wrap mod 4096
    {1'b0, 2'd0, 3'b100, 12'h047, 1'b0},  // R6 sleep
    {1'b1, 2'd1, 3'b100, 12'h047, 1'b0},  // R6 selects ignored while asleep
    {1'b1, 2'd1, 3'b000, 12'h14C, 1'b1},  // R6 resume from held phase
    {1'b0, 2'd1, 3'b001, 12'h100, 1'b1},  // R7 clear
    {1'b0, 2'd0, 3'b000, 12'h010, 1'b1},  // R7 restart from zero
    {1'b0, 2'd2, 3'b010, 12'h000, 1'b0},  // R5 reset flag
    {1'b1, 2'd3, 3'b010, 12'h000, 1'b0},  // R5 held at zero
    {1'b1, 2'd0, 3'b000, 12'h004, 1'b1},  // R5 first step after release
    {1'b0, 2'd0, 3'b101, 12'h004, 1'b0},  // R8 clear with sleep
    {1'b0, 2'd0, 3'b000, 12'h010, 1'b1},  // R8 accumulator was zeroed
    {1'b0, 2'd0, 3'b111, 12'h000, 1'b0},  // R8 reset flag wins
    {1'b0, 2'd3, 3'b000, 12'h00F, 1'b1}   // R3 wrap after restart
  };
  localparam int VREQ [NV] = '{2, 2, 4, 3, 4, 3, 6, 6, 6, 7, 7, 5, 5, 5, 8, 8, 8, 3};

  task automatic check(input int req, input logic [11:0] exp_ph, input logic exp_v);
    checks++;
    if (phase_word !== exp_ph || phase_vld !== exp_v) begin
      errors++;
      $display("FAIL R%0d: phase_word=%h vld=%b expected phase_word=%h vld=%b",
               req, phase_word, phase_vld, exp_ph, exp_v);
    end
  endtask

  task automatic step(input logic fs, input logic [1:0] ps, input logic [2:0] flags);
    @(negedge clk);
    ftw_sel   = fs;
    poff_sel  = ps;
    sleep_req = flags[2];
    rst_req   = flags[1];
    clr_req   = flags[0];
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ftw0 = 32'h0100_0000;
    ftw1 = 32'h0040_0000;
    ftw_sel = 1'b0; poff_sel = 2'd0;
    sleep_req = 1'b0; rst_req = 1'b0; clr_req = 1'b0;
    repeat (3) @(posedge clk);
    #2 check(1, 12'h000, 1'b0);  // R1 in reset
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 check(1, 12'h000, 1'b0);  // R1 during sync release
    @(posedge clk); #2;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17:16], VEC[i][15:13]);
      check(VREQ[i], VEC[i][12:1], VEC[i][0]);
    end

    // R9: tuning word at exactly half the clock rate
    @(negedge clk) ftw0 = 32'h8000_0000;
    step(1'b0, 2'd0, 3'b001);
    check(9, 12'h000, 1'b1);
    step(1'b0, 2'd0, 3'b000);
    check(9, 12'h800, 1'b1);
    step(1'b0, 2'd0, 3'b000);
    check(9, 12'h000, 1'b1);
    step(1'b0, 2'd0, 3'b000);
    check(9, 12'h800, 1'b1);

    // R1: asynchronous reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #2 check(1, 12'h000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #2 check(1, 12'h000, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule